// File: doc/BRIEF.md
# Dithered Five-Channel Pulse-Width Modulator

This block drives five output pins with pulse-width modulated waveforms that average out to an 8-bit level. Each channel holds an 8-bit word. The upper five bits set a coarse high time inside a cycle of 32 PWM clocks. The lower three bits, a binary rate multiplier count N, add one extra clock of high time to N of the 8 cycles in each frame. Averaged over a frame, a channel is high for 8 × coarse + N PWM clocks out of 256, which gives a DAC-like 8-bit result at a 32-clock repetition rate.

One shared prescaler divides the system clock by 2, 4, 8 or 16 to form the PWM clock, so one cycle repeats every 32 × divider system clocks. For example, a 20 MHz clock with a divider of 16 repeats at about 39.1 kHz. A per-channel enable selects the pin source: the modulated waveform when set, or the ordinary port-latch bit when clear. Software loads channel words, the divider select and the enables through a plain single-cycle write port. A write is accepted in every cycle, so the port has no back-pressure. New channel words reach the waveform only at a frame boundary. A write to the divider select restarts the whole timebase.

Top module: `dither_pwm`

## Requirements
- R1: After reset, all channel words are 0x00, the divider select is 0 (divide by 2) and all enables are clear, so every pin shows its port-latch bit.
- R2: Write map on `wr_addr`: addresses 0 to 4 load the word of channels 0 to 4; address 5 loads the divider select from `wr_data[1:0]`; address 6 loads the enables, with `wr_data[3+i]` enabling channel i, so 0x08 enables channel 0 alone. A write to address 7 changes nothing.
- R3: One PWM clock lasts 2^(select+1) system clocks: 2, 4, 8 or 16 for select 0 to 3.
- R4: A cycle lasts 32 PWM clocks. For coarse duty D (word bits 7:3), an enabled pin is high for PWM positions 0 to D-1 of the cycle and low for positions D+1 to 31.
- R5: A frame is 8 cycles, numbered 0 to 7. With N = word bits 2:0, the pin is also high at position D in the first N cycles of the order 0, 4, 2, 6, 1, 5, 3, 7. That is, cycle f gets the extra clock when the bit-reverse of f is less than N. A frame therefore holds 8·D + N high PWM clocks in total.
- R6: A written channel word takes effect at the first clock of the next frame. The frame in progress keeps the old word throughout.
- R7: A write to the divider select restarts the timebase at position 0 of cycle 0 from the next system clock. Every channel takes up its most recently written word at that restart.
- R8: A pin whose enable is clear follows its `port_latch` bit, and that bit reaches the pin in the same cycle it changes. A pin whose enable is set carries the modulated waveform.
- R9: The channels are independent: each pin's waveform depends only on its own word and enable, plus the shared timebase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, accepted every cycle |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| port_latch | input | 5 | Ordinary port-latch bits, one per channel pin |
| pwm_pin | output | 5 | Pin values, channel i on bit i |

## Verification
The checker assumes that only a write to address 5 can realign the timebase. It also assumes that `wr_en` and `wr_addr` carry known values in every cycle after reset. The bench meets this by driving every write for exactly one cycle on the falling clock edge, and by holding the strobe low in all other cycles. Each sweep starts from a restart, so the bench knows the phase of every sample. The checker compares the coarse high and low parts of each cycle against the active word only, so it does not depend on which frame boundary a data write lands near.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  parameter int DUTY_W = 5;
  parameter int BRM_W  = 3;
  localparam int WORD_W = DUTY_W + BRM_W;

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    logic [BRM_W-1:0]  brm;
  } chan_word_t;

  // mirror the bits of a frame index so the extra pulses spread evenly
  function automatic logic [BRM_W-1:0] bit_rev(input logic [BRM_W-1:0] v);
    logic [BRM_W-1:0] r;
    for (int k = 0; k < BRM_W; k++) r[k] = v[BRM_W-1-k];
    return r;
  endfunction
endpackage

// File: rtl/dpwm_prescale.sv
module dpwm_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = 1 << SEL_W;
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] limit;

  always_comb begin
    span  = ({{CNT_W{1'b0}}, 1'b1} << sel) << 1;
    limit = span[CNT_W-1:0] - ONE;
  end

  assign tick = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int POS_W = 5,
  parameter int FRM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  output logic [POS_W-1:0] pos,
  output logic [FRM_W-1:0] frame,
  output logic             frame_end
);
  localparam logic [POS_W-1:0] POS_ONE = 1;
  localparam logic [FRM_W-1:0] FRM_ONE = 1;

  logic [POS_W-1:0] pos_q;
  logic [FRM_W-1:0] frame_q;

  assign pos       = pos_q;
  assign frame     = frame_q;
  assign frame_end = tick && (&pos_q) && (&frame_q);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pos_q   <= '0;
      frame_q <= '0;
    end else if (tick) begin
      pos_q <= pos_q + POS_ONE;
      if (&pos_q) frame_q <= frame_q + FRM_ONE;
    end
  end
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
  import dpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  chan_word_t        next_word,
  input  logic [DUTY_W-1:0] pos,
  input  logic [BRM_W-1:0]  frame,
  input  logic              en,
  input  logic              latch_bit,
  output chan_word_t        word_q,
  output logic              pin
);
  logic extra;
  logic wave;

  always_ff @(posedge clk) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= next_word;
  end

  always_comb begin
    extra = (bit_rev(frame) < word_q.brm);
    wave  = (pos < word_q.duty) || ((pos == word_q.duty) && extra);
    pin   = en ? wave : latch_bit;
  end
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import dpwm_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [NUM_CH-1:0] port_latch,
  output logic [NUM_CH-1:0] pwm_pin
);
  localparam int SEL_ADDR = NUM_CH;
  localparam int EN_ADDR  = NUM_CH + 1;
  localparam int EN_LSB   = WORD_W - NUM_CH;

  chan_word_t [NUM_CH-1:0] shadow_q;
  chan_word_t [NUM_CH-1:0] active_w;
  logic [SEL_W-1:0]        sel_q;
  logic [NUM_CH-1:0]       en_q;
  logic                    restart;
  logic                    tick;
  logic                    frame_end;
  logic                    load;
  logic [DUTY_W-1:0]       pos_q;
  logic [BRM_W-1:0]        frame_q;

  assign restart = wr_en && (wr_addr == ADDR_W'(SEL_ADDR));
  assign load    = frame_end || restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      sel_q    <= '0;
      en_q     <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NUM_CH; c++)
        if (wr_addr == ADDR_W'(c)) shadow_q[c] <= wr_data;
      if (wr_addr == ADDR_W'(SEL_ADDR)) sel_q <= wr_data[SEL_W-1:0];
      if (wr_addr == ADDR_W'(EN_ADDR))  en_q  <= wr_data[EN_LSB +: NUM_CH];
    end
  end

  dpwm_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .sel(sel_q), .tick(tick)
  );

  dpwm_timebase #(.POS_W(DUTY_W), .FRM_W(BRM_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .pos(pos_q), .frame(frame_q), .frame_end(frame_end)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dpwm_channel u_ch (
      .clk(clk), .rst_n(rst_n), .load(load), .next_word(shadow_q[c]),
      .pos(pos_q), .frame(frame_q), .en(en_q[c]), .latch_bit(port_latch[c]),
      .word_q(active_w[c]), .pin(pwm_pin[c])
    );
  end
endmodule

// File: rtl/dither_pwm_chk.sv
module dither_pwm_chk
  import dpwm_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic [NUM_CH-1:0]       port_latch,
  input logic [NUM_CH-1:0]       pwm_pin,
  input logic [SEL_W-1:0]        sel_q,
  input logic [NUM_CH-1:0]       en_q,
  input logic                    tick,
  input logic [DUTY_W-1:0]       pos_q,
  input logic [BRM_W-1:0]        frame_q,
  input chan_word_t [NUM_CH-1:0] active_w
);
  localparam int CNT_W = 1 << SEL_W;
  localparam logic [CNT_W-1:0]  GAP_ONE = 1;
  localparam logic [DUTY_W-1:0] P_ONE   = 1;
  localparam logic [BRM_W-1:0]  F_ONE   = 1;

  logic             rs;
  logic [CNT_W-1:0] gap_q;
  logic [CNT_W-1:0] lim;

  assign rs  = wr_en && (wr_addr == ADDR_W'(NUM_CH));
  assign lim = CNT_W'((32'd1 << (int'(sel_q) + 1)) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n)          gap_q <= '0;
    else if (rs || tick) gap_q <= '0;
    else                 gap_q <= gap_q + GAP_ONE;
  end

  AST_PRESCALE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rs) |-> (gap_q == lim)); // R3
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !rs) |=> ($stable(pos_q) && $stable(frame_q))); // R3
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rs) |=> (pos_q == $past(pos_q) + P_ONE)); // R4
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rs && (&pos_q)) |=> (frame_q == $past(frame_q) + F_ONE)); // R5
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs && !(tick && (&pos_q) && (&frame_q))) |=> $stable(active_w)); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rs |=> (pos_q == '0 && frame_q == '0)); // R7
  AST_LATCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (((pwm_pin ^ port_latch) & ~en_q) == '0)); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_COARSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[c] && (pos_q < active_w[c].duty)) |-> pwm_pin[c]); // R4
    AST_COARSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[c] && (pos_q > active_w[c].duty)) |-> !pwm_pin[c]); // R4
  end
endmodule

bind dither_pwm dither_pwm_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .port_latch(port_latch), .pwm_pin(pwm_pin), .sel_q(sel_q), .en_q(en_q),
  .tick(tick), .pos_q(pos_q), .frame_q(frame_q), .active_w(active_w)
);

// File: tb/dither_pwm_bench.sv
module dither_pwm_bench;
  localparam int NCH = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] port_latch = '0;
  logic [4:0] pwm_pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int         div = 2;
  logic [7:0] act_d [NCH];
  logic [7:0] pend_d [NCH];
  logic [4:0] en_m = '0;
  int         mw_s = -1;
  logic [2:0] mw_addr = '0;
  logic [7:0] mw_val = '0;

  always #2 clk = ~clk;

  dither_pwm u_dither_pwm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .port_latch(port_latch), .pwm_pin(pwm_pin)
  );

  function automatic bit exp_bit(int s, logic [7:0] d, int dv);
    int p, f, rev, duty, n;
    p    = (s / dv) % 32;
    f    = (s / (dv * 32)) % 8;
    rev  = ((f & 1) << 2) | (f & 2) | ((f >> 2) & 1);
    duty = int'(d[7:3]);
    n    = int'(d[2:0]);
    return (p < duty) || (p == duty && rev < n);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_data(int ch, logic [7:0] d);
    wr(3'(ch), d);
    pend_d[ch] = d;
  endtask

  task automatic set_en(logic [4:0] m);
    wr(3'd6, {m, 3'b000});
    en_m = m;
  endtask

  task automatic restart_tb(int sel);
    wr(3'd5, 8'(sel));
    div = 2 << sel;
    for (int c = 0; c < NCH; c++) act_d[c] = pend_d[c];
  endtask

  // sample from phase s0 for n system clocks; s counts clocks since restart
  task automatic run(int s0, int n, string tag, bit avg_chk);
    int hi [NCH];
    int flen;
    logic [4:0] e;
    flen = div * 256;
    for (int c = 0; c < NCH; c++) hi[c] = 0;
    for (int s = s0; s < s0 + n; s++) begin
      if (s > 0 && s % flen == 0)
        for (int c = 0; c < NCH; c++) act_d[c] = pend_d[c];
      for (int c = 0; c < NCH; c++) begin
        e[c] = en_m[c] ? exp_bit(s, act_d[c], div) : port_latch[c];
        if (en_m[c] && pwm_pin[c]) hi[c]++;
      end
      chk(pwm_pin === e, tag, int'(pwm_pin), int'(e));
      if (s == mw_s) begin
        wr_en = 1'b1; wr_addr = mw_addr; wr_data = mw_val;
        if (mw_addr < 3'(NCH)) pend_d[mw_addr] = mw_val;
      end
      if (s == mw_s + 1) wr_en = 1'b0;
      if (s % 37 == 36) port_latch = port_latch ^ 5'b11111;
      @(negedge clk);
    end
    mw_s = -1;
    if (avg_chk)
      for (int c = 0; c < NCH; c++)
        if (en_m[c])
          chk(hi[c] == div * (8 * int'(act_d[c][7:3]) + int'(act_d[c][2:0])),
              "R5 frame high total", hi[c],
              div * (8 * int'(act_d[c][7:3]) + int'(act_d[c][2:0])));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] spec [NCH];
    spec[0] = 8'h05; spec[1] = 8'hFF; spec[2] = 8'h83; spec[3] = 8'h08; spec[4] = 8'hF1;
    for (int c = 0; c < NCH; c++) begin act_d[c] = '0; pend_d[c] = '0; end

    // R1: reset state, pins follow the latch
    port_latch = 5'b10110;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(pwm_pin === port_latch, "R1 reset pins follow latch", int'(pwm_pin), int'(port_latch));
    port_latch = 5'b01001;
    #1;
    chk(pwm_pin === port_latch, "R8 latch passes while disabled", int'(pwm_pin), int'(port_latch));

    // R1/R3/R6: default divide-by-2 timebase from reset, zero words, new word at frame 1
    set_data(0, 8'h83);
    set_en(5'b00001);
    run(4, 1024, "R1/R6 reset timebase and deferred word", 0);

    // R4/R5/R9: sweep words over all BRM counts at divide by 2
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < NCH; c++)
        set_data(c, (r == 0) ? spec[c] : {5'((r * 9 + c * 13 + 3) % 32), 3'((r + c) % 8)});
      set_en(5'b11111);
      restart_tb(0);
      run(0, 512, "R4/R5/R9 sweep", 1);
    end

    // R3: other dividers
    for (int sel = 1; sel < 4; sel++) begin
      for (int c = 0; c < NCH; c++) set_data(c, 8'((sel * 37 + c * 51 + 17) % 256));
      restart_tb(sel);
      run(0, div * 256, "R3 prescaler", 1);
    end

    // R6: mid-frame word change waits for the frame boundary
    for (int c = 0; c < NCH; c++) set_data(c, 8'h44);
    restart_tb(0);
    mw_s = 100; mw_addr = 3'd2; mw_val = 8'hB5;
    run(0, 1024, "R6 frame-aligned update", 0);

    // R2: address 7 writes are ignored
    restart_tb(0);
    mw_s = 50; mw_addr = 3'd7; mw_val = 8'hFF;
    run(0, 512, "R2 unused address ignored", 1);

    // R7: restart in mid-frame realigns and applies pending words
    run(0, 300, "R7 before restart", 0);
    set_data(1, 8'h27);
    set_data(3, 8'hC6);
    restart_tb(0);
    run(0, 512, "R7 restart realigns", 1);

    // R8: partial enable with toggling latch
    set_en(5'b01010);
    restart_tb(1);
    run(0, 1024, "R8 partial enable", 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule